// File: doc/BRIEF.md
# Dual-Processor Shared Mailbox

This block lets two processors exchange messages through one single-ported word store. Each processor has its own request/grant/ready port. An arbiter lets one access through per cycle, and processor A always wins. The store is split into two one-way mailboxes. The lower half carries traffic from B to A, and the upper half carries traffic from A to B.

The first word of each half is the command word, and the words after it hold the payload. A sender writes the payload first and then writes a nonzero command. The receiver copies the payload and writes zero to the command word to mark the message done. Writing zero to the command word is also how a sender withdraws a pending command.

The command words are held in dedicated registers that clear on reset. Each mailbox therefore exposes a pending flag that can be polled without a memory access. A per-mailbox watchdog flags a command that stays nonzero longer than a limit set on an input.

Top module: `dual_mailbox`

## Requirements
- R1: After reset both pending flags, both timeout flags and both ready outputs are 0, and a read of either command word (address 0 or address 1024) returns 0.
- R2: A port's grant is high in every cycle its request is high and the port is not blocked. The access is performed at the clock edge that ends that cycle. Ready is high in the following cycle only, and for a read, rdata holds the word last written to that address.
- R3: When both ports request in the same cycle, A is granted and B's grant stays low. B keeps its request and is granted in the first cycle in which A does not request.
- R4: Address bit 10 selects the mailbox: 0 is mailbox 0 (B to A), 1 is mailbox 1 (A to B). Bits 9:0 equal to zero address the command word. `cmd_pending[k]` equals (command word k != 0) and changes in the cycle after the write.
- R5: Writing zero to a command word clears its pending flag in the next cycle. Either port may do this, covering both completion and cancel.
- R6: A read of a command word returns its current value.
- R7: If a nonzero command is written at clock edge E, `cmd_timeout[k]` rises after edge E+`tmo_limit`+1, provided the word is not written again. Any write to the command word clears the flag in the next cycle and restarts the count.
- R8: Once set, a timeout flag stays set while no write to its command word occurs.
- R9: Writes to payload words (bits 9:0 nonzero) leave both pending flags and both timeout flags unchanged.
- R10: Activity on one mailbox never changes the other mailbox's pending or timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Port A access request, held until granted |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 11 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_gnt | output | 1 | Port A granted this cycle |
| a_rdy | output | 1 | Port A access completed |
| a_rdata | output | 16 | Port A read data, valid with a_rdy |
| b_req | input | 1 | Port B access request, held until granted |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 11 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_gnt | output | 1 | Port B granted this cycle |
| b_rdy | output | 1 | Port B access completed |
| b_rdata | output | 16 | Port B read data, valid with b_rdy |
| tmo_limit | input | 16 | Timeout threshold in cycles |
| cmd_pending | output | 2 | Per-mailbox command pending flag |
| cmd_timeout | output | 2 | Per-mailbox sticky timeout flag |

## Verification
Random mixes of reads and writes from both ports are run against a reference copy of the store. The addresses cluster on a few payload words and on the two command words, so read-after-write data and the pending flags are compared under interleaved traffic. Directed simultaneous requests separate a correct fixed priority from round-robin or B-first arbitration. Timeout runs with a small limit test the exact edge at which the flag rises, its stickiness, and its clearing on a write, so an off-by-one counter or a flag that clears on its own is detected. Payload writes made while the flags are steady confirm that only command-word writes move them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int unsigned MBX_AW  = 11;
    parameter int unsigned MBX_DW  = 16;
    parameter int unsigned MBX_TW  = 16;
    localparam int unsigned HALF_AW = MBX_AW - 1;
    localparam int unsigned NUM_BOX = 2;
    localparam int unsigned DEPTH   = 1 << MBX_AW;

    typedef struct packed {
        logic              we;
        logic [MBX_AW-1:0] addr;
        logic [MBX_DW-1:0] wdata;
    } mbx_acc_t;

    typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} mbx_src_t;

    function automatic logic box_of(input logic [MBX_AW-1:0] addr);
        return addr[MBX_AW-1];
    endfunction

    function automatic logic is_cmd(input logic [MBX_AW-1:0] addr);
        return addr[HALF_AW-1:0] == '0;
    endfunction
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
    import mbx_pkg::*;
(
    input  logic     req_a,
    input  logic     req_b,
    input  mbx_acc_t acc_a,
    input  mbx_acc_t acc_b,
    output logic     gnt_a,
    output logic     gnt_b,
    output logic     go,
    output mbx_src_t src,
    output mbx_acc_t acc
);
    always_comb begin
        gnt_a = req_a;
        gnt_b = req_b & ~req_a;
        go    = gnt_a | gnt_b;
        src   = gnt_a ? SRC_A : SRC_B;
        acc   = gnt_a ? acc_a : acc_b;
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           go,
    input  mbx_acc_t                       acc,
    output logic [MBX_DW-1:0]              rdata,
    output logic [NUM_BOX-1:0][MBX_DW-1:0] cmd_word,
    output logic [NUM_BOX-1:0]             cmd_wr
);
    logic [MBX_DW-1:0] mem [DEPTH];
    logic [NUM_BOX-1:0][MBX_DW-1:0] cmd_q;
    logic [MBX_DW-1:0] rdata_q;
    logic hit_cmd;
    logic sel_box;

    always_comb begin
        hit_cmd = is_cmd(acc.addr);
        sel_box = box_of(acc.addr);
        for (int k = 0; k < NUM_BOX; k++) begin
            cmd_wr[k] = go && acc.we && hit_cmd && (sel_box == k[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (go && acc.we && !hit_cmd) begin
            mem[acc.addr] <= acc.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            rdata_q <= '0;
        end else begin
            for (int k = 0; k < NUM_BOX; k++) begin
                if (cmd_wr[k]) cmd_q[k] <= acc.wdata;
            end
            if (go) begin
                if (acc.we)       rdata_q <= acc.wdata;
                else if (hit_cmd) rdata_q <= cmd_q[sel_box];
                else              rdata_q <= mem[acc.addr];
            end
        end
    end

    assign rdata    = rdata_q;
    assign cmd_word = cmd_q;
endmodule

// File: rtl/mbx_watch.sv
module mbx_watch
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              busy,
    input  logic [MBX_TW-1:0] limit,
    output logic              flag
);
    logic [MBX_TW-1:0] cnt_q;
    logic              flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (cmd_wr) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (!busy) begin
            cnt_q  <= '0;
        end else if (cnt_q == limit) begin
            flag_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [MBX_AW-1:0] a_addr,
    input  logic [MBX_DW-1:0] a_wdata,
    output logic              a_gnt,
    output logic              a_rdy,
    output logic [MBX_DW-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [MBX_AW-1:0] b_addr,
    input  logic [MBX_DW-1:0] b_wdata,
    output logic              b_gnt,
    output logic              b_rdy,
    output logic [MBX_DW-1:0] b_rdata,
    input  logic [MBX_TW-1:0] tmo_limit,
    output logic [1:0]        cmd_pending,
    output logic [1:0]        cmd_timeout
);
    mbx_acc_t acc_a, acc_b, acc;
    mbx_src_t src;
    logic     go;
    logic     rdy_a_q, rdy_b_q;
    logic [MBX_DW-1:0] rdata;
    logic [NUM_BOX-1:0][MBX_DW-1:0] cmd_word;
    logic [NUM_BOX-1:0] cmd_wr;

    assign acc_a = '{we: a_we, addr: a_addr, wdata: a_wdata};
    assign acc_b = '{we: b_we, addr: b_addr, wdata: b_wdata};

    mbx_arbiter u_arb (
        .req_a(a_req), .req_b(b_req), .acc_a(acc_a), .acc_b(acc_b),
        .gnt_a(a_gnt), .gnt_b(b_gnt), .go(go), .src(src), .acc(acc)
    );

    mbx_store u_store (
        .clk(clk), .rst(rst), .go(go), .acc(acc),
        .rdata(rdata), .cmd_word(cmd_word), .cmd_wr(cmd_wr)
    );

    for (genvar k = 0; k < NUM_BOX; k++) begin : g_box
        assign cmd_pending[k] = cmd_word[k] != '0;
        mbx_watch u_watch (
            .clk(clk), .rst(rst), .cmd_wr(cmd_wr[k]),
            .busy(cmd_pending[k]), .limit(tmo_limit), .flag(cmd_timeout[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_a_q <= 1'b0;
            rdy_b_q <= 1'b0;
        end else begin
            rdy_a_q <= go && (src == SRC_A);
            rdy_b_q <= go && (src == SRC_B);
        end
    end

    assign a_rdy   = rdy_a_q;
    assign b_rdy   = rdy_b_q;
    assign a_rdata = rdata;
    assign b_rdata = rdata;
endmodule

// File: rtl/mailbox_checker.sv
module mailbox_checker
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              a_req,
    input logic              a_we,
    input logic [MBX_AW-1:0] a_addr,
    input logic              a_gnt,
    input logic              a_rdy,
    input logic              b_req,
    input logic              b_we,
    input logic [MBX_AW-1:0] b_addr,
    input logic              b_gnt,
    input logic              b_rdy,
    input logic [1:0]        cmd_pending,
    input logic [1:0]        cmd_timeout
);
    logic [1:0] wr_cmd;
    always_comb begin
        for (int k = 0; k < 2; k++) begin
            wr_cmd[k] = (a_gnt && a_we && is_cmd(a_addr) && box_of(a_addr) == k[0]) ||
                        (b_gnt && b_we && is_cmd(b_addr) && box_of(b_addr) == k[0]);
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (cmd_pending == 2'b00 && cmd_timeout == 2'b00 && !a_rdy && !b_rdy)); // R1
    AST_A_PRECEDES: assert property (@(posedge clk) disable iff (rst) (a_req && b_req) |-> (a_gnt && !b_gnt)); // R3
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst) !(a_gnt && b_gnt)); // R3
    AST_RDY_AFTER_A: assert property (@(posedge clk) disable iff (rst) a_gnt |=> a_rdy); // R2
    AST_RDY_AFTER_B: assert property (@(posedge clk) disable iff (rst) b_gnt |=> b_rdy); // R2
    AST_NO_STRAY_RDY: assert property (@(posedge clk) disable iff (rst) !(a_gnt || b_gnt) |=> !(a_rdy || b_rdy)); // R2
    AST_PEND0_HOLDS: assert property (@(posedge clk) disable iff (rst) !wr_cmd[0] |=> $stable(cmd_pending[0])); // R9
    AST_PEND1_HOLDS: assert property (@(posedge clk) disable iff (rst) !wr_cmd[1] |=> $stable(cmd_pending[1])); // R10
    AST_TMO0_CLEARS: assert property (@(posedge clk) disable iff (rst) wr_cmd[0] |=> !cmd_timeout[0]); // R7
    AST_TMO1_CLEARS: assert property (@(posedge clk) disable iff (rst) wr_cmd[1] |=> !cmd_timeout[1]); // R7
    AST_TMO0_STICKY: assert property (@(posedge clk) disable iff (rst) (cmd_timeout[0] && !wr_cmd[0]) |=> cmd_timeout[0]); // R8
    AST_TMO1_STICKY: assert property (@(posedge clk) disable iff (rst) (cmd_timeout[1] && !wr_cmd[1]) |=> cmd_timeout[1]); // R8
endmodule

bind dual_mailbox mailbox_checker chk_i (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_gnt(a_gnt), .a_rdy(a_rdy),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_gnt(b_gnt), .b_rdy(b_rdy),
    .cmd_pending(cmd_pending), .cmd_timeout(cmd_timeout)
);

// File: tb/dual_mailbox_tb_top.sv
module dual_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [10:0] a_addr = 0, b_addr = 0;
    logic [15:0] a_wdata = 0, b_wdata = 0;
    logic        a_gnt, a_rdy, b_gnt, b_rdy;
    logic [15:0] a_rdata, b_rdata;
    logic [15:0] tmo_limit = 16'd60000;
    logic [1:0]  cmd_pending, cmd_timeout;

    int tests = 0;
    int fails = 0;
    logic [15:0] ref_mem [0:2047];
    bit          ref_ok  [0:2047];

    always #4 clk = ~clk;

    dual_mailbox dut_i (
        .clk(clk), .rst(rst),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_gnt(a_gnt), .a_rdy(a_rdy), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_gnt(b_gnt), .b_rdy(b_rdy), .b_rdata(b_rdata),
        .tmo_limit(tmo_limit), .cmd_pending(cmd_pending), .cmd_timeout(cmd_timeout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pending();
        return {ref_mem[1024] != 0, ref_mem[0] != 0};
    endfunction

    task automatic do_acc(input int port, input logic we, input logic [10:0] addr,
                          input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        if (port == 0) begin a_req = 1; a_we = we; a_addr = addr; a_wdata = wd; end
        else           begin b_req = 1; b_we = we; b_addr = addr; b_wdata = wd; end
        #1;
        while ((port == 0) ? !a_gnt : !b_gnt) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        if (port == 0) begin a_req = 0; check("R2 rdy A", a_rdy, 1); rd = a_rdata; end
        else           begin b_req = 0; check("R2 rdy B", b_rdy, 1); rd = b_rdata; end
        if (we) begin ref_mem[addr] = wd; ref_ok[addr] = 1; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2048; i++) begin ref_ok[i] = 0; ref_mem[i] = 0; end
        ref_ok[0] = 1; ref_ok[1024] = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 pending", cmd_pending, 0);
        check("R1 timeout", cmd_timeout, 0);
        check("R1 rdy", {a_rdy, b_rdy}, 0);
        do_acc(0, 0, 11'd0, 0, rd);    check("R1 cmd0 read", rd, 0);
        do_acc(1, 0, 11'd1024, 0, rd); check("R1 cmd1 read", rd, 0);

        // R9 payload writes leave flags alone
        do_acc(0, 1, 11'd1025, 16'h1234, rd);
        do_acc(1, 1, 11'd1, 16'hBEEF, rd);
        check("R9 pending after payload", cmd_pending, 0);
        do_acc(1, 0, 11'd1025, 0, rd); check("R2 payload read", rd, 16'h1234);

        // R4 / R10 command into mailbox 1 only
        do_acc(0, 1, 11'd1024, 16'h0007, rd);
        check("R4 pending mbox1", cmd_pending, 2'b10);
        do_acc(1, 0, 11'd1024, 0, rd); check("R6 cmd read", rd, 16'h0007);
        do_acc(1, 1, 11'd1024, 16'h0000, rd);
        check("R5 complete clears", cmd_pending, 2'b00);
        // R5 cancel by sender on mailbox 0
        do_acc(1, 1, 11'd0, 16'h00A5, rd);
        check("R4 pending mbox0", cmd_pending, 2'b01);
        do_acc(1, 1, 11'd0, 16'h0000, rd);
        check("R5 cancel clears", cmd_pending, 2'b00);

        // R3 simultaneous requests
        @(negedge clk);
        a_req = 1; a_we = 1; a_addr = 11'd1030; a_wdata = 16'hAAAA;
        b_req = 1; b_we = 1; b_addr = 11'd6;    b_wdata = 16'hBBBB;
        #1;
        check("R3 A granted", a_gnt, 1);
        check("R3 B waits", b_gnt, 0);
        @(negedge clk);
        a_req = 0;
        check("R3 A rdy", a_rdy, 1);
        #1;
        check("R3 B granted next", b_gnt, 1);
        @(negedge clk);
        b_req = 0;
        check("R3 B rdy", b_rdy, 1);
        ref_mem[1030] = 16'hAAAA; ref_ok[1030] = 1;
        ref_mem[6] = 16'hBBBB;    ref_ok[6] = 1;
        do_acc(0, 0, 11'd6, 0, rd); check("R3 B data landed", rd, 16'hBBBB);

        // R7 / R8 timeout on mailbox 1, limit 5
        tmo_limit = 16'd5;
        do_acc(0, 1, 11'd1024, 16'h0033, rd);
        repeat (5) @(negedge clk);
        check("R7 not yet", cmd_timeout, 2'b00);
        @(negedge clk);
        check("R7 rises", cmd_timeout, 2'b10);
        do_acc(0, 1, 11'd1027, 16'h5555, rd);
        repeat (3) @(negedge clk);
        check("R8 sticky", cmd_timeout, 2'b10);
        check("R10 other box", cmd_timeout[0], 0);
        do_acc(1, 1, 11'd1024, 16'h0000, rd);
        check("R7 write clears", cmd_timeout, 2'b00);
        check("R5 pending cleared", cmd_pending, 2'b00);
        // R7 limit 0 edge case on mailbox 0
        tmo_limit = 16'd0;
        do_acc(1, 1, 11'd0, 16'h0001, rd);
        check("R7 limit0 not yet", cmd_timeout, 2'b00);
        @(negedge clk);
        check("R7 limit0 rises", cmd_timeout, 2'b01);
        do_acc(0, 1, 11'd0, 16'h0000, rd);
        check("R7 limit0 clear", cmd_timeout, 2'b00);

        // random traffic against model (R2, R4, R6)
        tmo_limit = 16'd60000;
        for (int i = 0; i < 400; i++) begin
            int port = $urandom % 2;
            logic we = 1'($urandom % 2);
            logic box = 1'($urandom % 2);
            logic cmd = ($urandom % 4) == 0;
            logic [10:0] addr = {box, cmd ? 10'd0 : 10'(1 + $urandom % 12)};
            logic [15:0] wd = (cmd && ($urandom % 2)) ? 16'h0 : 16'($urandom);
            logic [15:0] exp = ref_mem[addr];
            logic        known = ref_ok[addr];
            do_acc(port, we, addr, wd, rd);
            if (!we && known) check(cmd ? "R6 rand cmd read" : "R2 rand read", rd, exp);
            check("R4 rand pending", cmd_pending, exp_pending());
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule